// File: doc/BRIEF.md
# Cluster Write-Port and Global-Bus Arbiter

This block decides, within a single cycle, which function-unit result writes may proceed. Every function unit belongs to one cluster and may ask to write its result into the register file of any cluster. Two kinds of resource are contested. The first is the set of write ports on each register file. Those ports are split into a reserved pool, open only to units of the same cluster, and a shared pool that any unit may use. The second is a small set of global buses that carry writes between clusters.

For each requester the block returns either an acknowledge or a stall, and for each acknowledged write the port index and the bus index it was given. Requesters are served strictly from the lowest unit number to the highest. A unit that is told to stall is expected to present the same request again on later cycles until it is acknowledged. A two-bit mode input selects how much sharing is enforced. In the unconstrained mode everything is granted. In the port-only mode only destination ports are counted. In the bus-and-port mode a remote write also needs a global bus.

Top module: `cluster_write_arbiter`

## Requirements
- R1: For every unit, `wr_ack` and `wr_stall` are never both high; exactly one is high when `wr_req` is high, and both are low when it is low. A unit without an acknowledge reports port index 0 and bus index 0, and the destination of an idle unit has no effect.
- R2: `mode_sel` selects the interconnect mode: 0 is unconstrained, 1 is port-only, and 2 or 3 is bus-and-port. In the unconstrained mode every request is acknowledged and reports port 0 and bus 0.
- R3: In the port-only mode, remote writes never wait for a bus. More remote writes than there are global buses can be acknowledged in the same cycle, limited only by the free shared ports, and every bus index reads 0.
- R4: In the bus-and-port mode, a remote write is acknowledged only when both a global bus and a shared port of the destination are free. It takes the lowest free bus, no two acknowledged remote writes share a bus, and the acknowledged remote writes never outnumber the buses.
- R5: Units are served in ascending unit number, so a lower-numbered unit receives a contested resource before any higher-numbered unit. A stalled request presented again is acknowledged once the competing request is gone.
- R6: A local write, meaning a write to the unit's own cluster (unit u belongs to cluster u / UNITS_PER_CLUSTER), takes the lowest free reserved port (ports 0 to LOCAL_PORTS-1). If no reserved port is free, it takes the lowest free shared port. It stalls only when neither is free.
- R7: A remote write is given only a shared port (index LOCAL_PORTS or above) of its destination, namely the lowest free one. It stalls when all shared ports are taken, even if a reserved port is free.
- R8: In the constrained modes, no two acknowledged writes are given the same port of the same register file.
- R9: A remote write that stalls in the bus-and-port mode for lack of a bus holds no destination port. A later unit can therefore still take that shared port.
- R10: With no requests present, including right after reset, all acknowledges, stalls, port indices and bus indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset for the embedded checks |
| mode_sel | input | 2 | Interconnect mode (0 unconstrained, 1 port-only, 2/3 bus-and-port) |
| wr_req | input | NUM_UNITS | Write request per unit |
| wr_dest | input | NUM_UNITS*CL_W | Destination cluster per unit, unit u in slice u |
| wr_ack | output | NUM_UNITS | Write acknowledged this cycle |
| wr_stall | output | NUM_UNITS | Write refused, unit must hold and retry |
| port_sel | output | NUM_UNITS*PORT_W | Assigned destination port per unit |
| bus_sel | output | NUM_UNITS*BUS_W | Assigned global bus per unit |

## Verification
Port allocation and bus allocation are resolved in the same cycle, and in the bus-and-port mode they meet on one request: a remote write can find a shared port free while the only bus is already taken. This is provoked by sending two remote writes to one cluster while local writes to that same cluster follow at higher unit numbers. The second remote write must stall. The higher local writes are then judged by the exact port numbers they receive, which shows that the stalled remote write held no shared port. The same request pattern is also repeated in the port-only mode, where both remote writes must pass.

// File: rtl/wr_arb_pkg.sv
// Package: shared constants and helpers for the cluster write arbiter.
// Assumes: nothing; pure declarations.
package wr_arb_pkg;

    // Interconnect mode codes carried on mode_sel (3 behaves as 2)
    localparam logic [1:0] MODE_OPEN   = 2'd0;
    localparam logic [1:0] MODE_PORTS  = 2'd1;
    localparam logic [1:0] MODE_BUSPRT = 2'd2;

    // Index width for a field selecting one of n items, never below 1
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wr_arb_pick.sv
// Module: lowest-set-bit finder. Reports whether any bit of avail is set
// and the index of the lowest one.
// Assumes: W >= 1 and IW wide enough to hold W-1.
module wr_arb_pick #(
    parameter int W  = 4,
    parameter int IW = 2
) (
    input  logic [W-1:0]  avail,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so that the lowest set bit is written last
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (avail[i]) idx = IW'(i);
        end
    end

    // Any candidate at all
    assign found = |avail;

endmodule

// File: rtl/wr_arb_stage.sv
// Module: arbitration step for one function unit. Takes the port and bus
// occupancy left by lower-numbered units and decides this unit's write,
// then passes the updated occupancy on to the next unit.
// Assumes: HOME is the unit's own cluster; occupancy inputs come from the
// previous stage (or all-free for unit 0).
module wr_arb_stage
    import wr_arb_pkg::*;
#(
    parameter int NC   = 2,
    parameter int TP   = 3,
    parameter int LP   = 1,
    parameter int NB   = 1,
    parameter int HOME = 0,
    localparam int CW  = idx_w(NC),
    localparam int PW  = idx_w(TP),
    localparam int BW  = idx_w(NB)
) (
    input  logic [1:0]       mode,
    input  logic             valid,
    input  logic [CW-1:0]    dest,
    input  logic [NC*TP-1:0] port_busy_i,
    input  logic [NB-1:0]    bus_busy_i,
    output logic [NC*TP-1:0] port_busy_o,
    output logic [NB-1:0]    bus_busy_o,
    output logic             grant,
    output logic             stall,
    output logic [PW-1:0]    port_idx,
    output logic [BW-1:0]    bus_idx
);

    localparam logic [TP-1:0] ONE_P    = TP'(1);
    localparam logic [TP-1:0] RES_MASK = (ONE_P << LP) - ONE_P;
    localparam logic [NB-1:0] ONE_B    = NB'(1);

    logic [TP-1:0] dest_busy;
    logic [TP-1:0] avail_res;
    logic [TP-1:0] avail_sh;
    logic [NB-1:0] avail_bus;
    logic          res_ok, sh_ok, bus_ok;
    logic [PW-1:0] res_idx, sh_idx;
    logic [BW-1:0] bus_pick;
    logic          is_local, m_open, m_ports;
    logic          take_port, take_bus;

    // Occupancy of the destination register file; unknown cluster looks full
    always_comb begin
        dest_busy = '1;
        for (int c = 0; c < NC; c++) begin
            if (int'(dest) == c) dest_busy = port_busy_i[c*TP +: TP];
        end
    end

    assign avail_res = ~dest_busy & RES_MASK;
    assign avail_sh  = ~dest_busy & ~RES_MASK;
    assign avail_bus = ~bus_busy_i;
    assign is_local  = (int'(dest) == HOME);
    assign m_open    = (mode == MODE_OPEN);
    assign m_ports   = (mode == MODE_PORTS);

    wr_arb_pick #(.W(TP), .IW(PW)) i_pick_res (
        .avail(avail_res), .found(res_ok), .idx(res_idx)
    );
    wr_arb_pick #(.W(TP), .IW(PW)) i_pick_sh (
        .avail(avail_sh), .found(sh_ok), .idx(sh_idx)
    );
    wr_arb_pick #(.W(NB), .IW(BW)) i_pick_bus (
        .avail(avail_bus), .found(bus_ok), .idx(bus_pick)
    );

    // Decide this unit's grant and which resources it consumes
    always_comb begin
        grant     = 1'b0;
        port_idx  = '0;
        bus_idx   = '0;
        take_port = 1'b0;
        take_bus  = 1'b0;
        if (valid) begin
            if (m_open) begin
                grant = 1'b1;
            end else if (is_local) begin
                if (res_ok) begin
                    grant     = 1'b1;
                    port_idx  = res_idx;
                    take_port = 1'b1;
                end else if (sh_ok) begin
                    grant     = 1'b1;
                    port_idx  = sh_idx;
                    take_port = 1'b1;
                end
            end else if (sh_ok && (m_ports || bus_ok)) begin
                grant     = 1'b1;
                port_idx  = sh_idx;
                take_port = 1'b1;
                if (!m_ports) begin
                    bus_idx  = bus_pick;
                    take_bus = 1'b1;
                end
            end
        end
    end

    assign stall = valid & ~grant;

    // Mark the port taken by this unit for the stages that follow
    always_comb begin
        port_busy_o = port_busy_i;
        for (int c = 0; c < NC; c++) begin
            for (int p = 0; p < TP; p++) begin
                if (take_port && int'(dest) == c && int'(port_idx) == p)
                    port_busy_o[c*TP + p] = 1'b1;
            end
        end
    end

    // Mark the bus taken by this unit
    assign bus_busy_o = take_bus ? (bus_busy_i | (ONE_B << bus_pick)) : bus_busy_i;

endmodule

// File: rtl/cluster_write_arbiter.sv
// Module: top of the cluster write arbiter. Chains one arbitration stage per
// function unit in ascending unit order, so each unit sees only the ports and
// buses left over by lower-numbered units. Purely combinational; clk and
// rst_n serve the embedded checks only.
// Assumes: units are numbered cluster by cluster, UNITS_PER_CLUSTER each;
// LOCAL_PORTS <= TOTAL_PORTS; a stalled unit re-presents its request.
module cluster_write_arbiter
    import wr_arb_pkg::*;
#(
    parameter int NUM_CLUSTERS      = 2,
    parameter int UNITS_PER_CLUSTER = 3,
    parameter int NUM_BUSES         = 1,
    parameter int TOTAL_PORTS       = 3,
    parameter int LOCAL_PORTS       = 1,
    localparam int NUM_UNITS = NUM_CLUSTERS * UNITS_PER_CLUSTER,
    localparam int CL_W      = idx_w(NUM_CLUSTERS),
    localparam int PORT_W    = idx_w(TOTAL_PORTS),
    localparam int BUS_W     = idx_w(NUM_BUSES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  mode_sel,
    input  logic [NUM_UNITS-1:0]        wr_req,
    input  logic [NUM_UNITS*CL_W-1:0]   wr_dest,
    output logic [NUM_UNITS-1:0]        wr_ack,
    output logic [NUM_UNITS-1:0]        wr_stall,
    output logic [NUM_UNITS*PORT_W-1:0] port_sel,
    output logic [NUM_UNITS*BUS_W-1:0]  bus_sel
);

    localparam int NPB = NUM_CLUSTERS * TOTAL_PORTS;

    // Occupancy threaded from stage to stage
    logic [NPB-1:0]       port_chain [NUM_UNITS+1];
    logic [NUM_BUSES-1:0] bus_chain  [NUM_UNITS+1];

    assign port_chain[0] = '0;
    assign bus_chain[0]  = '0;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        wr_arb_stage #(
            .NC(NUM_CLUSTERS), .TP(TOTAL_PORTS), .LP(LOCAL_PORTS),
            .NB(NUM_BUSES), .HOME(u / UNITS_PER_CLUSTER)
        ) i_stage (
            .mode        (mode_sel),
            .valid       (wr_req[u]),
            .dest        (wr_dest[u*CL_W +: CL_W]),
            .port_busy_i (port_chain[u]),
            .bus_busy_i  (bus_chain[u]),
            .port_busy_o (port_chain[u+1]),
            .bus_busy_o  (bus_chain[u+1]),
            .grant       (wr_ack[u]),
            .stall       (wr_stall[u]),
            .port_idx    (port_sel[u*PORT_W +: PORT_W]),
            .bus_idx     (bus_sel[u*BUS_W +: BUS_W])
        );
    end

    // ---------------- embedded checks ----------------
    logic [NUM_UNITS-1:0] remote_w;
    logic                 port_clash, bus_clash;

    // Which requests cross clusters (checker view)
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++)
            remote_w[u] = int'(wr_dest[u*CL_W +: CL_W]) != (u / UNITS_PER_CLUSTER);
    end

    // Pairwise search for doubly assigned ports or buses
    always_comb begin
        port_clash = 1'b0;
        bus_clash  = 1'b0;
        for (int a = 0; a < NUM_UNITS; a++) begin
            for (int b = a + 1; b < NUM_UNITS; b++) begin
                if (mode_sel != MODE_OPEN && wr_ack[a] && wr_ack[b] &&
                    wr_dest[a*CL_W +: CL_W] == wr_dest[b*CL_W +: CL_W] &&
                    port_sel[a*PORT_W +: PORT_W] == port_sel[b*PORT_W +: PORT_W])
                    port_clash = 1'b1;
                if (mode_sel[1] && wr_ack[a] && wr_ack[b] && remote_w[a] && remote_w[b] &&
                    bus_sel[a*BUS_W +: BUS_W] == bus_sel[b*BUS_W +: BUS_W])
                    bus_clash = 1'b1;
            end
        end
    end

    p_full_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == MODE_OPEN) |-> (wr_ack == wr_req));

    p_bus_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel[1] |-> ($countones(wr_ack & remote_w) <= NUM_BUSES));

    p_bus_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clash);

    p_port_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_clash);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req == '0) |-> (wr_ack == '0 && wr_stall == '0));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        p_ack_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ack[u] ^ wr_stall[u]) == wr_req[u]);

        p_remote_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_sel != MODE_OPEN && wr_ack[u] && remote_w[u])
                |-> (int'(port_sel[u*PORT_W +: PORT_W]) >= LOCAL_PORTS));
    end

endmodule

// File: tb/test_cluster_write_arbiter.sv
module test_cluster_write_arbiter;

    // Defaults: 2 clusters x 3 units, 1 bus, 3 ports per file, 1 reserved
    localparam int NU = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [5:0]  wr_req = '0;
    logic [5:0]  wr_dest = '0;
    logic [5:0]  wr_ack, wr_stall;
    logic [11:0] port_sel;
    logic [5:0]  bus_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cluster_write_arbiter i_cluster_write_arbiter (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_req(wr_req),
        .wr_dest(wr_dest), .wr_ack(wr_ack), .wr_stall(wr_stall),
        .port_sel(port_sel), .bus_sel(bus_sel)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [5:0]  req;
        logic [5:0]  dest;
        logic [5:0]  ack;
        logic [11:0] port;
        logic [5:0]  bus;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'b111111, 6'b000000, 6'b111111, 12'd0, 6'd0},
        '{2'd1, 6'b111111, 6'b000000, 6'b000111,
          {2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0}, 6'd0},
        '{2'd1, 6'b111000, 6'b000000, 6'b011000,
          {2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0}, 6'd0},
        '{2'd2, 6'b111000, 6'b000000, 6'b001000,
          {2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0}, 6'd0},
        '{2'd2, 6'b111000, 6'b110000, 6'b111000,
          {2'd1, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0}, 6'd0},
        '{2'd2, 6'b111011, 6'b111011, 6'b011001,
          {2'd0, 2'd2, 2'd0, 2'd0, 2'd0, 2'd1}, 6'd0},
        '{2'd3, 6'b111000, 6'b000000, 6'b001000,
          {2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0}, 6'd0},
        '{2'd1, 6'b000000, 6'b000000, 6'b000000, 12'd0, 6'd0},
        '{2'd1, 6'b100111, 6'b100111, 6'b100011,
          {2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1}, 6'd0},
        '{2'd1, 6'b111011, 6'b111011, 6'b001011,
          {2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1}, 6'd0},
        '{2'd0, 6'b101010, 6'b110011, 6'b101010, 12'd0, 6'd0}
    };
    localparam string TAGS [NV] = '{"R2", "R6", "R3", "R4", "R4", "R9",
                                    "R2", "R10", "R7", "R5", "R1"};

    // Compare all outputs against expected values for one stimulus
    task automatic check_out(input string tag, input logic [5:0] req,
                             input logic [5:0] e_ack, input logic [11:0] e_port,
                             input logic [5:0] e_bus);
        logic [5:0] e_stall;
        e_stall = req & ~e_ack;
        n_tests++;
        if (wr_ack !== e_ack) begin
            n_fail++;
            $display("FAIL %s ack actual=%b expected=%b", tag, wr_ack, e_ack);
        end
        n_tests++;
        if (wr_stall !== e_stall) begin
            n_fail++;
            $display("FAIL %s stall actual=%b expected=%b", tag, wr_stall, e_stall);
        end
        n_tests++;
        if (port_sel !== e_port || bus_sel !== e_bus) begin
            n_fail++;
            $display("FAIL %s port/bus actual=%h/%h expected=%h/%h",
                     tag, port_sel, bus_sel, e_port, e_bus);
        end
    endtask

    // Drive away from the rising edge, then sample mid-phase
    task automatic apply(input logic [1:0] m, input logic [5:0] r, input logic [5:0] d);
        @(negedge clk);
        mode_sel = m;
        wr_req   = r;
        wr_dest  = d;
        #5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // R10: outputs quiet while reset is held and no request is present
        #5;
        check_out("R10", 6'b0, 6'b0, 12'd0, 6'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].mode, VECS[i].req, VECS[i].dest);
            check_out(TAGS[i], VECS[i].req, VECS[i].ack, VECS[i].port, VECS[i].bus);
        end

        // R8: every unit writes locally, each file fills ports 0,1,2
        apply(2'd1, 6'b111111, 6'b111000);
        check_out("R8", 6'b111111, 6'b111111,
                  {2'd2, 2'd1, 2'd0, 2'd2, 2'd1, 2'd0}, 6'd0);

        // R5: u4 stalls behind u3 for the bus, retries and wins once u3 leaves
        apply(2'd2, 6'b011000, 6'b000000);
        check_out("R5", 6'b011000, 6'b001000,
                  {2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0}, 6'd0);
        apply(2'd2, 6'b010000, 6'b000000);
        check_out("R5", 6'b010000, 6'b010000,
                  {2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0}, 6'd0);

        // R6: two locals in cluster 1 with the reserved port already contested
        apply(2'd2, 6'b011000, 6'b011000);
        check_out("R6", 6'b011000, 6'b011000,
                  {2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0}, 6'd0);

        // R10: back to idle
        apply(2'd2, 6'b000000, 6'b111111);
        check_out("R10", 6'b0, 6'b0, 12'd0, 6'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is reported as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule